// File: doc/BRIEF.md
# Shared Data Memory with Round-Robin Access Hub

This block owns a word-addressed data memory (1024 words of 32 bits by default). Three agents share it. A memory-mapped port reaches either a small set of control registers or the memory itself. A bulk mover copies a programmed run of words between the memory and a pair of streams. A local processor port reads and writes words directly. A round-robin arbiter gives the memory to one requester per cycle, so every agent sees a bounded wait and all of them see the same memory contents.

The memory-mapped port splits one byte address space into two parts. The bottom 256 bytes hold the control registers. Above them, word n sits at byte offset 256 + 4·n. The streams and the processor port address memory in whole words, with no byte arithmetic. Software sets the direction, the first word and the word count, then raises the transfer-start bit. The mover performs the run once, then waits until that bit is cleared. Clearing the bit while a run is in progress stops the run and returns the mover to idle. Two further register bits choose whether the processor is released by the run bit or by an external start input.

Top module: `shared_dmem_hub`

## Requirements
- R1: After reset the control registers read as follows: start source 0, run 0, direction 0, transfer start 0, first word 0, count 100. mm_ack, cpu_ack, m_tvalid, s_tready and core_go are all low.
- R2: Register k sits at byte offset 4·k of the memory-mapped port. k=0 is the start source (1 bit), k=1 is run (1 bit), k=2 is direction (1 bit), k=3 is transfer start (1 bit), k=4 is the first word (10 bits) and k=5 is the count (11 bits). A write stores the low bits and a read returns them zero-extended. Any other offset below 256 reads as 0 and ignores writes.
- R3: Byte offset 256 + 4·n on the memory-mapped port reaches the same memory word that the processor port reaches at word address n.
- R4: A memory-mapped access at byte offset 256 + 4·1024 or higher is acknowledged with read data 0 and does not change the memory.
- R5: A request stays high until its ack. A register access or an out-of-range access is acknowledged in the cycle after the request. A memory access is acknowledged in the cycle after its grant. The ack lasts one cycle, and read data is valid while ack is high.
- R6: The memory performs at most one access per cycle. Grants rotate round-robin among the memory-mapped port, the bulk mover and the processor port, so a requester that stays high waits at most two cycles.
- R7: With direction 0, a rising transfer start makes the master stream deliver `count` words, starting at the first word and wrapping modulo 1024, in address order. m_tlast is high only on the final word.
- R8: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R9: With direction 1, the slave stream accepts exactly `count` words and writes them to consecutive words starting at the first word. After that s_tready stays low.
- R10: A finished run is not repeated while transfer start stays 1. Clearing transfer start in the middle of a run drops m_tvalid and s_tready within two cycles.
- R11: A count of 0 moves no words in either direction.
- R12: core_go follows the run bit when the start source is 0, and follows ext_start when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_req | input | 1 | Memory-mapped request, held until mm_ack |
| mm_we | input | 1 | Memory-mapped write when 1 |
| mm_addr | input | 13 | Memory-mapped byte address |
| mm_wdata | input | 32 | Memory-mapped write data |
| mm_ack | output | 1 | Memory-mapped one-cycle acknowledge |
| mm_rdata | output | 32 | Memory-mapped read data, valid with mm_ack |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | Processor write when 1 |
| cpu_addr | input | 10 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ack | output | 1 | Processor one-cycle acknowledge |
| cpu_rdata | output | 32 | Processor read data, valid with cpu_ack |
| s_tvalid | input | 1 | Slave stream valid |
| s_tready | output | 1 | Slave stream ready |
| s_tdata | input | 32 | Slave stream data |
| m_tvalid | output | 1 | Master stream valid |
| m_tready | input | 1 | Master stream ready |
| m_tdata | output | 32 | Master stream data |
| m_tlast | output | 1 | Master stream final word |
| ext_start | input | 1 | External processor start |
| core_go | output | 1 | Processor release |

## Verification
Register and data-window accesses are driven from a vector table that uses all-ones, sparse and unused-offset patterns. These show up wrong field widths, wrong register order and a missing boundary between the register window and the data window. Read transfers run with a stalling ready pattern and start near the top of memory. This separates correct wrap-around and hold-under-backpressure from designs that skip or repeat words or drop them during a stall. Write transfers are offered more words than the count, which shows whether the mover stops at exactly `count`. Memory-mapped and processor reads run concurrently with a streaming read to measure how long each waits, which tells a rotating arbiter apart from a fixed-priority one.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  // agent slots on the arbiter; slot order is also the rotation order
  localparam int AG_MM    = 0;
  localparam int AG_MOVER = 1;
  localparam int AG_CPU   = 2;
  localparam int AG_COUNT = 3;

  // control register slots (byte offset = 4 * slot)
  localparam int RI_SRC  = 0;
  localparam int RI_RUN  = 1;
  localparam int RI_DIR  = 2;
  localparam int RI_GO   = 3;
  localparam int RI_BASE = 4;
  localparam int RI_CNT  = 5;

  typedef enum logic [2:0] {
    MV_IDLE,
    MV_FETCH,
    MV_CATCH,
    MV_SEND,
    MV_TAKE,
    MV_STORE,
    MV_DONE
  } mover_st_t;

endpackage

// File: rtl/rr_grant.sv
module rr_grant #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [IW-1:0] last_q;
  logic [IW-1:0] win;
  logic          found;

  // search starts one slot past the previous winner
  always_comb begin
    gnt   = '0;
    win   = last_q;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      logic [IW-1:0] idx;
      idx = IW'((int'(last_q) + k) % N);
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win      = idx;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (found) begin
      last_q <= win;
    end
  end

  // checker state: cycles each requester has waited
  localparam int CW = $clog2(N + 1) + 1;
  for (genvar g = 0; g < N; g++) begin : g_wait
    logic [CW-1:0] wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wait_q <= '0;
      end else if (req[g] && !gnt[g]) begin
        wait_q <= wait_q + 1'b1;
      end else begin
        wait_q <= '0;
      end
    end
    // R6: a held request waits at most N-1 cycles
    a_r6_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(wait_q) < N));
  end

  // R6: single grant, only to a requester
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r6_granted_requests: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0));

endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import dmem_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 32,
  parameter int DEF_CNT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [5:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic          start_src,
  output logic          run,
  output logic          dir,
  output logic          go,
  output logic [AW-1:0] base,
  output logic [AW:0]   cnt
);

  localparam logic [AW:0] CNT_RST = (AW + 1)'(DEF_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_src <= 1'b0;
      run       <= 1'b0;
      dir       <= 1'b0;
      go        <= 1'b0;
      base      <= '0;
      cnt       <= CNT_RST;
    end else if (wr_en) begin
      if (int'(sel) == RI_SRC)  start_src <= wdata[0];
      if (int'(sel) == RI_RUN)  run       <= wdata[0];
      if (int'(sel) == RI_DIR)  dir       <= wdata[0];
      if (int'(sel) == RI_GO)   go        <= wdata[0];
      if (int'(sel) == RI_BASE) base      <= wdata[AW-1:0];
      if (int'(sel) == RI_CNT)  cnt       <= wdata[AW:0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (int'(sel))
      RI_SRC:  rd_val[0]      = start_src;
      RI_RUN:  rd_val[0]      = run;
      RI_DIR:  rd_val[0]      = dir;
      RI_GO:   rd_val[0]      = go;
      RI_BASE: rd_val[AW-1:0] = base;
      RI_CNT:  rd_val[AW:0]   = cnt;
      default: rd_val         = '0;
    endcase
  end

endmodule

// File: rtl/bulk_mover.sv
module bulk_mover
  import dmem_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          to_mem,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   cnt,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          gnt,
  input  logic [DW-1:0] mem_rd,
  output logic          m_tvalid,
  input  logic          m_tready,
  output logic [DW-1:0] m_tdata,
  output logic          m_tlast,
  input  logic          s_tvalid,
  output logic          s_tready,
  input  logic [DW-1:0] s_tdata
);

  mover_st_t     st_q, st_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic [AW:0]   left_q, left_n;
  logic [DW-1:0] hold_q, hold_n;
  logic          final_word;

  assign final_word = (left_q == (AW + 1)'(1));

  always_comb begin
    st_n   = st_q;
    ptr_n  = ptr_q;
    left_n = left_q;
    hold_n = hold_q;
    req_o  = 1'b0;
    we_o   = 1'b0;
    case (st_q)
      MV_IDLE: if (go) begin
        ptr_n  = base;
        left_n = cnt;
        if (cnt == '0)   st_n = MV_DONE;
        else if (to_mem) st_n = MV_TAKE;
        else             st_n = MV_FETCH;
      end
      MV_FETCH: begin
        req_o = 1'b1;
        if (gnt) begin
          ptr_n = ptr_q + 1'b1;
          st_n  = MV_CATCH;
        end
      end
      MV_CATCH: begin
        hold_n = mem_rd;
        st_n   = MV_SEND;
      end
      MV_SEND: if (m_tready) begin
        left_n = left_q - 1'b1;
        st_n   = final_word ? MV_DONE : MV_FETCH;
      end
      MV_TAKE: if (s_tvalid) begin
        hold_n = s_tdata;
        st_n   = MV_STORE;
      end
      MV_STORE: begin
        req_o = 1'b1;
        we_o  = 1'b1;
        if (gnt) begin
          ptr_n  = ptr_q + 1'b1;
          left_n = left_q - 1'b1;
          st_n   = final_word ? MV_DONE : MV_TAKE;
        end
      end
      MV_DONE: if (!go) st_n = MV_IDLE;
      default: st_n = MV_IDLE;
    endcase
    if (!go) begin
      st_n  = MV_IDLE;
      req_o = 1'b0;
      we_o  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MV_IDLE;
      ptr_q  <= '0;
      left_q <= '0;
      hold_q <= '0;
    end else begin
      st_q   <= st_n;
      ptr_q  <= ptr_n;
      left_q <= left_n;
      hold_q <= hold_n;
    end
  end

  assign addr_o   = ptr_q;
  assign wdata_o  = hold_q;
  assign m_tvalid = (st_q == MV_SEND);
  assign m_tdata  = hold_q;
  assign m_tlast  = m_tvalid && final_word;
  assign s_tready = (st_q == MV_TAKE) && go;

  // R8: an unaccepted word holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && go) |=>
      (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
  // R7: nothing follows the final word of a run
  a_r7_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);
  // R9: one word is accepted, then stored before the next is taken
  a_r9_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) |=> !s_tready);
  // R10: clearing start abandons the run
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!go) |=> (!s_tready && !req_o));

endmodule

// File: rtl/shared_dmem_hub.sv
module shared_dmem_hub
  import dmem_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int REG_BYTES = 256,
  parameter int DEF_CNT   = 100,
  localparam int DEPTH    = 1 << AW,
  localparam int MM_AW    = $clog2(REG_BYTES + 4 * DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mm_req,
  input  logic             mm_we,
  input  logic [MM_AW-1:0] mm_addr,
  input  logic [DW-1:0]    mm_wdata,
  output logic             mm_ack,
  output logic [DW-1:0]    mm_rdata,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ack,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic [DW-1:0]    s_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [DW-1:0]    m_tdata,
  output logic             m_tlast,
  input  logic             ext_start,
  output logic             core_go
);

  // ---------------- memory-mapped decode ----------------
  logic [MM_AW-1:0] mm_off;
  logic             reg_hit, data_hit, mm_new;
  logic [AW-1:0]    mm_word;

  assign mm_off   = mm_addr - MM_AW'(REG_BYTES);
  assign reg_hit  = (mm_addr < MM_AW'(REG_BYTES));
  assign data_hit = !reg_hit && (mm_off < MM_AW'(4 * DEPTH));
  assign mm_word  = mm_off[AW+1:2];
  assign mm_new   = mm_req && !mm_ack;

  // ---------------- control registers ----------------
  logic [DW-1:0] reg_val;
  logic          r_src, r_run, r_dir, r_go;
  logic [AW-1:0] r_base;
  logic [AW:0]   r_cnt;

  ctrl_regs #(.AW(AW), .DW(DW), .DEF_CNT(DEF_CNT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mm_new && reg_hit && mm_we),
    .sel       (mm_addr[7:2]),
    .wdata     (mm_wdata),
    .rd_val    (reg_val),
    .start_src (r_src),
    .run       (r_run),
    .dir       (r_dir),
    .go        (r_go),
    .base      (r_base),
    .cnt       (r_cnt)
  );

  assign core_go = r_src ? ext_start : r_run;

  // ---------------- bulk mover ----------------
  logic          mv_req, mv_we;
  logic [AW-1:0] mv_addr;
  logic [DW-1:0] mv_wdata;
  logic [DW-1:0] mem_rd;
  logic [AG_COUNT-1:0] req, gnt;

  bulk_mover #(.AW(AW), .DW(DW)) u_mover (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (r_go),
    .to_mem   (r_dir),
    .base     (r_base),
    .cnt      (r_cnt),
    .req_o    (mv_req),
    .we_o     (mv_we),
    .addr_o   (mv_addr),
    .wdata_o  (mv_wdata),
    .gnt      (gnt[AG_MOVER]),
    .mem_rd   (mem_rd),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tdata  (s_tdata)
  );

  // ---------------- arbitration ----------------
  assign req[AG_MM]    = mm_new && data_hit;
  assign req[AG_MOVER] = mv_req;
  assign req[AG_CPU]   = cpu_req && !cpu_ack;

  rr_grant #(.N(AG_COUNT)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  logic [AW-1:0] ag_addr [AG_COUNT];
  logic          ag_we   [AG_COUNT];
  logic [DW-1:0] ag_wd   [AG_COUNT];
  logic [AW-1:0] m_addr;
  logic          m_we, any_gnt;
  logic [DW-1:0] m_wd;

  assign ag_addr[AG_MM]    = mm_word;
  assign ag_we[AG_MM]      = mm_we;
  assign ag_wd[AG_MM]      = mm_wdata;
  assign ag_addr[AG_MOVER] = mv_addr;
  assign ag_we[AG_MOVER]   = mv_we;
  assign ag_wd[AG_MOVER]   = mv_wdata;
  assign ag_addr[AG_CPU]   = cpu_addr;
  assign ag_we[AG_CPU]     = cpu_we;
  assign ag_wd[AG_CPU]     = cpu_wdata;
  assign any_gnt           = |gnt;

  always_comb begin
    m_addr = '0;
    m_we   = 1'b0;
    m_wd   = '0;
    for (int k = 0; k < AG_COUNT; k++) begin
      if (gnt[k]) begin
        m_addr = ag_addr[k];
        m_we   = ag_we[k];
        m_wd   = ag_wd[k];
      end
    end
  end

  // ---------------- storage: one port, one access per cycle ----------------
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (any_gnt) begin
      if (m_we) store[m_addr] <= m_wd;
      mem_rd <= store[m_addr];
    end
  end

  // ---------------- acknowledges ----------------
  logic          mm_from_mem;
  logic [DW-1:0] mm_hold;
  logic          mm_ack_n;

  assign mm_ack_n = (mm_new && !data_hit) || gnt[AG_MM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_ack      <= 1'b0;
      cpu_ack     <= 1'b0;
      mm_from_mem <= 1'b0;
      mm_hold     <= '0;
    end else begin
      mm_ack  <= mm_ack_n;
      cpu_ack <= gnt[AG_CPU];
      if (mm_new) begin
        mm_from_mem <= data_hit;
        mm_hold     <= reg_hit ? reg_val : '0;
      end
    end
  end

  assign mm_rdata  = mm_from_mem ? mem_rd : mm_hold;
  assign cpu_rdata = mem_rd;

  // R5: acks are single-cycle pulses
  a_r5_mm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mm_ack |=> !mm_ack);
  a_r5_cpu_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  // R4: accesses past the data window answer at once with zero
  a_r4_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && !mm_ack && !reg_hit && !data_hit) |=>
      (mm_ack && (mm_rdata == '0)));
  // R6: the hole never reaches the memory
  a_r6_hole_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_hit && !data_hit) |-> !gnt[AG_MM]);

endmodule

// File: tb/tb_shared_dmem_hub.sv
module tb_shared_dmem_hub;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mm_req, mm_we;
  logic [12:0] mm_addr;
  logic [31:0] mm_wdata, mm_rdata;
  logic        mm_ack;
  logic        cpu_req, cpu_we, cpu_ack;
  logic [9:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        s_tvalid, s_tready;
  logic [31:0] s_tdata;
  logic        m_tvalid, m_tready, m_tlast;
  logic [31:0] m_tdata;
  logic        ext_start, core_go;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  shared_dmem_hub dut (
    .clk(clk), .rst_n(rst_n),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_ack(mm_ack), .mm_rdata(mm_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .ext_start(ext_start), .core_go(core_go)
  );

  // addr, write data, expected read-back
  localparam logic [95:0] VEC [12] = '{
    {32'h0000, 32'hFFFF_FFFF, 32'h0000_0001},   // R2 source
    {32'h0004, 32'hFFFF_FFFE, 32'h0000_0000},   // R2 run
    {32'h0008, 32'h0000_0003, 32'h0000_0001},   // R2 direction
    {32'h0010, 32'hFFFF_FFFF, 32'h0000_03FF},   // R2 first word
    {32'h0014, 32'hFFFF_FFFF, 32'h0000_07FF},   // R2 count
    {32'h0018, 32'h0000_1234, 32'h0000_0000},   // R2 unused slot
    {32'h00FC, 32'h0000_0005, 32'h0000_0000},   // R2 last unused slot
    {32'h0010, 32'h0000_0155, 32'h0000_0155},   // R2 sparse
    {32'h0014, 32'h0000_002A, 32'h0000_002A},   // R2 sparse
    {32'h0100, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R3 word 0
    {32'h10FC, 32'h0BAD_F00D, 32'h0BAD_F00D},   // R3 word 1023
    {32'h1100, 32'h1234_5678, 32'h0000_0000}    // R4 past the window
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mm_xfer(input logic we, input logic [12:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat);
    @(negedge clk);
    mm_req = 1'b1; mm_we = we; mm_addr = a; mm_wdata = wd;
    lat = 0;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      lat++;
      if (mm_ack) break;
    end
    rd = mm_rdata;
    mm_req = 1'b0; mm_we = 1'b0;
  endtask

  task automatic cpu_xfer(input logic we, input logic [9:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    lat = 0;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      lat++;
      if (cpu_ack) break;
    end
    rd = cpu_rdata;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic mm_wr(input logic [12:0] a, input logic [31:0] d);
    logic [31:0] r; int l;
    mm_xfer(1'b1, a, d, r, l);
  endtask

  task automatic cpu_wr(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] r; int l;
    cpu_xfer(1'b1, a, d, r, l);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    logic [31:0] got [8];
    logic        gl  [8];
    int n, acc;
    logic pv, pr;
    logic [31:0] pd;

    rst_n = 1'b0; mm_req = 0; mm_we = 0; mm_addr = '0; mm_wdata = '0;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    s_tvalid = 0; s_tdata = '0; m_tready = 0; ext_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 mm_ack", {31'b0, mm_ack}, 32'h0);
    check("R1 cpu_ack", {31'b0, cpu_ack}, 32'h0);
    check("R1 m_tvalid", {31'b0, m_tvalid}, 32'h0);
    check("R1 s_tready", {31'b0, s_tready}, 32'h0);
    check("R1 core_go", {31'b0, core_go}, 32'h0);
    for (int k = 0; k < 6; k++) begin
      mm_xfer(1'b0, 13'(4 * k), '0, rd, lat);
      check("R1 register default", rd, (k == 5) ? 32'd100 : 32'd0);
    end
    // R5: register access acks one cycle later, for one cycle
    mm_xfer(1'b0, 13'h14, '0, rd, lat);
    check("R5 register ack latency", 32'(lat), 32'd1);
    @(negedge clk);
    check("R5 ack is a pulse", {31'b0, mm_ack}, 32'h0);

    // vector table: write, then read back
    for (int v = 0; v < 12; v++) begin
      logic [12:0] a;
      a = VEC[v][76:64];
      mm_wr(a, VEC[v][63:32]);
      mm_xfer(1'b0, a, '0, rd, lat);
      check(v < 9 ? "R2 table" : (v < 11 ? "R3 table" : "R4 table"), rd, VEC[v][31:0]);
    end
    // R3 / R4: processor view agrees; the hole changed nothing
    cpu_xfer(1'b0, 10'd0, '0, rd, lat);
    check("R4 word 0 untouched by hole write", rd, 32'hDEAD_BEEF);
    check("R5 memory ack latency", 32'(lat), 32'd1);
    cpu_xfer(1'b0, 10'd1023, '0, rd, lat);
    check("R3 top word via processor", rd, 32'h0BAD_F00D);
    cpu_wr(10'd7, 32'h7777_0007);
    mm_xfer(1'b0, 13'h11C, '0, rd, lat);
    check("R3 processor write seen at byte 0x11C", rd, 32'h7777_0007);
    mm_wr(13'h000, 32'h0);
    mm_wr(13'h008, 32'h0);

    // R12: processor release source
    mm_wr(13'h004, 32'h1);
    @(negedge clk);
    check("R12 run drives core_go", {31'b0, core_go}, 32'h1);
    mm_wr(13'h000, 32'h1);
    @(negedge clk);
    check("R12 external low", {31'b0, core_go}, 32'h0);
    ext_start = 1'b1;
    @(negedge clk);
    check("R12 external high", {31'b0, core_go}, 32'h1);
    mm_wr(13'h000, 32'h0);
    mm_wr(13'h004, 32'h0);
    @(negedge clk);
    check("R12 run cleared", {31'b0, core_go}, 32'h0);
    ext_start = 1'b0;

    // R7 / R8: read run wrapping past the top, with stalls
    cpu_wr(10'd1022, 32'hA000_0000);
    cpu_wr(10'd1023, 32'hA000_0001);
    cpu_wr(10'd0,    32'hA000_0002);
    cpu_wr(10'd1,    32'hA000_0003);
    mm_wr(13'h010, 32'd1022);
    mm_wr(13'h014, 32'd4);
    mm_wr(13'h008, 32'd0);
    mm_wr(13'h00C, 32'd1);
    n = 0; pv = 0; pr = 0; pd = '0;
    for (int c = 0; c < 300 && n < 4; c++) begin
      @(negedge clk);
      if (pv && !pr) begin
        check("R8 valid held", {31'b0, m_tvalid}, 32'h1);
        check("R8 data held", m_tdata, pd);
      end
      m_tready = (c % 3 != 1);
      if (m_tvalid && m_tready) begin
        got[n] = m_tdata; gl[n] = m_tlast; n++;
      end
      pv = m_tvalid; pr = m_tready; pd = m_tdata;
    end
    check("R7 word count", 32'(n), 32'd4);
    for (int k = 0; k < 4; k++) begin
      check("R7 word order", got[k], 32'hA000_0000 + 32'(k));
      check("R7 last flag", {31'b0, gl[k]}, (k == 3) ? 32'h1 : 32'h0);
    end
    // R10: no repeat while start stays set
    acc = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (m_tvalid) acc++;
    end
    check("R10 no repeat after finish", 32'(acc), 32'd0);
    mm_wr(13'h00C, 32'd0);

    // R6: concurrent memory-mapped and processor reads during a read run
    mm_wr(13'h010, 32'd0);
    mm_wr(13'h014, 32'd16);
    m_tready = 1'b1;
    mm_wr(13'h00C, 32'd1);
    fork
      begin
        for (int i = 0; i < 4; i++) begin
          logic [31:0] r1; int l1;
          mm_xfer(1'b0, 13'h104, '0, r1, l1);
          check("R6 mm wait bound", (l1 <= 3) ? 32'h1 : 32'h0, 32'h1);
        end
      end
      begin
        for (int i = 0; i < 4; i++) begin
          logic [31:0] r2; int l2;
          cpu_xfer(1'b0, 10'd2, '0, r2, l2);
          check("R6 cpu wait bound", (l2 <= 3) ? 32'h1 : 32'h0, 32'h1);
        end
      end
    join
    repeat (80) @(negedge clk);
    mm_wr(13'h00C, 32'd0);

    // R10: abort in the middle of a read run
    m_tready = 1'b0;
    mm_wr(13'h014, 32'd10);
    mm_wr(13'h00C, 32'd1);
    for (int c = 0; c < 30 && !m_tvalid; c++) @(negedge clk);
    check("R10 run started", {31'b0, m_tvalid}, 32'h1);
    mm_wr(13'h00C, 32'd0);
    repeat (2) @(negedge clk);
    check("R10 valid dropped on abort", {31'b0, m_tvalid}, 32'h0);

    // R9: write run takes exactly the count
    cpu_wr(10'd53, 32'h0000_5353);
    mm_wr(13'h008, 32'd1);
    mm_wr(13'h010, 32'd50);
    mm_wr(13'h014, 32'd3);
    s_tdata = 32'hB000_0000; s_tvalid = 1'b1;
    mm_wr(13'h00C, 32'd1);
    acc = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (s_tready) begin
        acc++;
        @(negedge clk);
        s_tdata = s_tdata + 1;
      end
    end
    check("R9 accepted count", 32'(acc), 32'd3);
    check("R9 ready low after count", {31'b0, s_tready}, 32'h0);
    s_tvalid = 1'b0;
    mm_wr(13'h00C, 32'd0);
    for (int k = 0; k < 3; k++) begin
      cpu_xfer(1'b0, 10'(50 + k), '0, rd, lat);
      check("R9 stored word", rd, 32'hB000_0000 + 32'(k));
    end
    cpu_xfer(1'b0, 10'd53, '0, rd, lat);
    check("R9 word after run untouched", rd, 32'h0000_5353);

    // R11: zero count, both directions
    mm_wr(13'h014, 32'd0);
    s_tvalid = 1'b1;
    mm_wr(13'h00C, 32'd1);
    acc = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (s_tready) acc++;
    end
    check("R11 zero count write", 32'(acc), 32'd0);
    mm_wr(13'h00C, 32'd0);
    s_tvalid = 1'b0;
    mm_wr(13'h008, 32'd0);
    m_tready = 1'b1;
    mm_wr(13'h00C, 32'd1);
    acc = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (m_tvalid) acc++;
    end
    check("R11 zero count read", 32'(acc), 32'd0);
    mm_wr(13'h00C, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule